// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects the interrupt causes of a graphics engine and presents them to the host as one interrupt line. It handles three sources. The first is the binner running out of memory. The second is the binning stage finishing its flush. The third is the renderer completing a frame. The host works through a simple register port. A pending register shows which causes have fired, and the host clears bits in it by writing ones. Two separate registers change the enable mask: one sets enable bits and the other clears them. Both read back the same mask.

The two completion sources are single-cycle events that stay latched until the host clears them. The out-of-memory source is different. Once the binner reports exhaustion, the condition stays active, and clearing the pending bit does not remove it while the condition holds. The host ends the condition by writing new memory into one of two pool registers, which hold a base and a length. The pool values are driven straight to the binner. The interrupt line is registered.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset, the pending bits, the enable mask and both pool registers read as zero, and `irq_o` is low.
- R2: A write to the pending register (address 0) clears each pending bit whose data bit is 1. Bits written as 0 keep their value. A pending bit never rises unless its source has signalled.
- R3: A write to the enable-set register (address 1) sets each enable bit whose data bit is 1. Bits written as 0 are unchanged.
- R4: A write to the enable-clear register (address 2) clears each enable bit whose data bit is 1. Bits written as 0 are unchanged.
- R5: A read of address 1 and a read of address 2 both return the current enable mask in bits 2:0, with zeros above.
- R6: A one-cycle pulse on `flush_done_evt` sets pending bit 1, and a pulse on `frame_done_evt` sets pending bit 2. Each bit then stays set until it is cleared by a write of 1.
- R7: A pulse on `bin_oom_evt` starts an out-of-memory condition, and pending bit 0 is set in the next cycle. While the condition lasts, a write of 1 to bit 0 leaves the bit set.
- R8: A write to the pool base register (address 3) or the pool length register (address 4) ends the out-of-memory condition, unless `bin_oom_evt` is high in the same cycle. After that, a write of 1 clears bit 0, and the bit stays low until the next `bin_oom_evt` pulse.
- R9: The pool base register holds `POOL_BASE_W` bits and the pool length register holds `POOL_LEN_W` bits, both taken from the low bits of the write data. Each reads back zero-extended and is also driven on `pool_base_o` and `pool_len_o`.
- R10: `irq_o` is the OR over all bits of (pending AND enable). It is registered, and it reflects a register write or a source event one clock after that event.
- R11: If a source event and a write-1-to-clear of the same pending bit occur in the same cycle, the bit ends up set.
- R12: Reads of addresses 5 and above return zero, and writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the addressed register (combinational); zero when no read is requested |
| bin_oom_evt | input | 1 | Binner reports that memory is exhausted (pulse) |
| flush_done_evt | input | 1 | Binning flush finished (pulse) |
| frame_done_evt | input | 1 | Render frame finished (pulse) |
| irq_o | output | 1 | Registered interrupt line to the host |
| pool_base_o | output | POOL_BASE_W | Current overflow pool base |
| pool_len_o | output | POOL_LEN_W | Current overflow pool length |

## Verification
A stuck or lost pending bit shows in two places: on the next read of address 0, and on `irq_o` one clock after the enable mask exposes that bit. Sweeping every enable mask against every combination of sources makes each such fault visible within a few cycles. A condition flag that is wrongly held or wrongly released shows when a write of 1 to bit 0 fails to clear it, or clears it too early. This is checked right after a pool write and again after idle cycles. An enable mask that the set and clear registers see differently shows in the first pair of reads from addresses 1 and 2.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int unsigned NSRC      = 3;
  localparam int unsigned SRC_OOM   = 0;
  localparam int unsigned SRC_FLUSH = 1;
  localparam int unsigned SRC_FRAME = 2;

  localparam int unsigned A_PENDING = 0;
  localparam int unsigned A_EN_SET  = 1;
  localparam int unsigned A_EN_CLR  = 2;
  localparam int unsigned A_POOL_B  = 3;
  localparam int unsigned A_POOL_L  = 4;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef struct packed {
    logic pend_clr;
    logic en_set;
    logic en_clr;
    logic pool_base;
    logic pool_len;
  } wr_strobe_t;

  typedef enum logic [2:0] {
    RS_NONE, RS_PENDING, RS_ENABLE, RS_POOL_B, RS_POOL_L
  } rd_sel_e;

  // sticky bit update: a set in the same cycle beats a clear
  function automatic src_vec_t sticky_next(src_vec_t cur, src_vec_t clr, src_vec_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic src_vec_t mask_next(src_vec_t cur, src_vec_t set, src_vec_t clr);
    return (cur | set) & ~clr;
  endfunction

  function automatic logic irq_any(src_vec_t pend, src_vec_t en);
    return |(pend & en);
  endfunction
endpackage

// File: rtl/gfx_irq_decode.sv
module gfx_irq_decode
  import gfx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output wr_strobe_t        wr,
  output rd_sel_e           rd_sel
);
  logic hit_pend, hit_eset, hit_eclr, hit_pb, hit_pl;
  logic do_wr, do_rd;

  assign hit_pend = (req_addr == ADDR_W'(A_PENDING));
  assign hit_eset = (req_addr == ADDR_W'(A_EN_SET));
  assign hit_eclr = (req_addr == ADDR_W'(A_EN_CLR));
  assign hit_pb   = (req_addr == ADDR_W'(A_POOL_B));
  assign hit_pl   = (req_addr == ADDR_W'(A_POOL_L));

  assign do_wr = req_valid & req_write;
  assign do_rd = req_valid & ~req_write;

  always_comb begin
    wr.pend_clr  = do_wr & hit_pend;
    wr.en_set    = do_wr & hit_eset;
    wr.en_clr    = do_wr & hit_eclr;
    wr.pool_base = do_wr & hit_pb;
    wr.pool_len  = do_wr & hit_pl;
  end

  always_comb begin
    rd_sel = RS_NONE;
    if (do_rd) begin
      if (hit_pend)                 rd_sel = RS_PENDING;
      else if (hit_eset | hit_eclr) rd_sel = RS_ENABLE;
      else if (hit_pb)              rd_sel = RS_POOL_B;
      else if (hit_pl)              rd_sel = RS_POOL_L;
    end
  end
endmodule

// File: rtl/gfx_irq_pending.sv
module gfx_irq_pending
  import gfx_irq_pkg::*;
#(
  parameter src_vec_t LEVEL_MASK = src_vec_t'(1 << SRC_OOM)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_wr,
  input  src_vec_t clr_bits,
  input  src_vec_t evt,
  input  src_vec_t level,
  output src_vec_t pend_d,
  output src_vec_t pend_q
);
  src_vec_t set_v, clr_v;

  assign clr_v = clr_wr ? clr_bits : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      // held source: re-asserted every cycle its condition stands
      assign set_v[i] = evt[i] | level[i];
    end else begin : g_pulse
      assign set_v[i] = evt[i];
    end
  end

  assign pend_d = sticky_next(pend_q, clr_v, set_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/gfx_irq_mask.sv
module gfx_irq_mask
  import gfx_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_wr,
  input  logic     clr_wr,
  input  src_vec_t bits,
  output src_vec_t en_d,
  output src_vec_t en_q
);
  src_vec_t set_v, clr_v;

  assign set_v = set_wr ? bits : '0;
  assign clr_v = clr_wr ? bits : '0;
  assign en_d  = mask_next(en_q, set_v, clr_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/gfx_irq_pool.sv
module gfx_irq_pool #(
  parameter int unsigned BASE_W = 32,
  parameter int unsigned LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic              len_wr,
  input  logic [BASE_W-1:0] base_wdata,
  input  logic [LEN_W-1:0]  len_wdata,
  input  logic              oom_evt,
  output logic              pool_wr,
  output logic              oom_cond_q,
  output logic [BASE_W-1:0] base_q,
  output logic [LEN_W-1:0]  len_q
);
  assign pool_wr = base_wr | len_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      len_q      <= '0;
      oom_cond_q <= 1'b0;
    end else begin
      if (base_wr) base_q <= base_wdata;
      if (len_wr)  len_q  <= len_wdata;
      // a fresh exhaustion report outranks a supply in the same cycle
      if (oom_evt)      oom_cond_q <= 1'b1;
      else if (pool_wr) oom_cond_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned POOL_BASE_W = 32,
  parameter int unsigned POOL_LEN_W  = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   bin_oom_evt,
  input  logic                   flush_done_evt,
  input  logic                   frame_done_evt,
  output logic                   irq_o,
  output logic [POOL_BASE_W-1:0] pool_base_o,
  output logic [POOL_LEN_W-1:0]  pool_len_o
);
  wr_strobe_t wr;
  rd_sel_e    rd_sel;
  src_vec_t   src_evt, src_level, wbits;
  src_vec_t   pend_d, pend_q, en_d, en_q;
  logic       pool_wr, oom_cond_q, irq_q;

  assign wbits = req_wdata[NSRC-1:0];

  always_comb begin
    src_evt            = '0;
    src_evt[SRC_OOM]   = bin_oom_evt;
    src_evt[SRC_FLUSH] = flush_done_evt;
    src_evt[SRC_FRAME] = frame_done_evt;
    src_level          = '0;
    src_level[SRC_OOM] = oom_cond_q;
  end

  gfx_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr        (wr),
    .rd_sel    (rd_sel)
  );

  gfx_irq_pending u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_wr   (wr.pend_clr),
    .clr_bits (wbits),
    .evt      (src_evt),
    .level    (src_level),
    .pend_d   (pend_d),
    .pend_q   (pend_q)
  );

  gfx_irq_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (wr.en_set),
    .clr_wr (wr.en_clr),
    .bits   (wbits),
    .en_d   (en_d),
    .en_q   (en_q)
  );

  gfx_irq_pool #(.BASE_W(POOL_BASE_W), .LEN_W(POOL_LEN_W)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_wr    (wr.pool_base),
    .len_wr     (wr.pool_len),
    .base_wdata (req_wdata[POOL_BASE_W-1:0]),
    .len_wdata  (req_wdata[POOL_LEN_W-1:0]),
    .oom_evt    (bin_oom_evt),
    .pool_wr    (pool_wr),
    .oom_cond_q (oom_cond_q),
    .base_q     (pool_base_o),
    .len_q      (pool_len_o)
  );

  // registered line, computed from the values the state takes at this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_any(pend_d, en_d);
  end
  assign irq_o = irq_q;

  always_comb begin
    unique case (rd_sel)
      RS_PENDING: rd_data = DATA_W'(pend_q);
      RS_ENABLE:  rd_data = DATA_W'(en_q);
      RS_POOL_B:  rd_data = DATA_W'(pool_base_o);
      RS_POOL_L:  rd_data = DATA_W'(pool_len_o);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gfx_irq_chk.sv
module gfx_irq_chk
  import gfx_irq_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input src_vec_t evt,
  input src_vec_t pend_q,
  input src_vec_t en_q,
  input src_vec_t wbits,
  input logic     oom_cond_q,
  input logic     pool_wr,
  input logic     en_set_wr,
  input logic     en_clr_wr,
  input logic     irq_o
);
  a_r3_en_set: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_wr |=> ((en_q & $past(wbits)) == $past(wbits)));

  a_r4_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_wr |=> ((en_q & $past(wbits)) == '0));

  // R11: the event wins over a clear landing in the same cycle
  a_r6_flush_latch: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SRC_FLUSH] |=> pend_q[SRC_FLUSH]);

  a_r6_frame_latch: assert property (@(posedge clk) disable iff (!rst_n)
    evt[SRC_FRAME] |=> pend_q[SRC_FRAME]);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q[SRC_FLUSH] && !evt[SRC_FLUSH]) |=> !pend_q[SRC_FLUSH]);

  a_r7_oom_held: assert property (@(posedge clk) disable iff (!rst_n)
    oom_cond_q |=> pend_q[SRC_OOM]);

  a_r8_pool_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_wr && !evt[SRC_OOM]) |=> !oom_cond_q);

  a_r10_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(pend_q & en_q));
endmodule

bind gfx_irq_ctrl gfx_irq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt        (src_evt),
  .pend_q     (pend_q),
  .en_q       (en_q),
  .wbits      (wbits),
  .oom_cond_q (oom_cond_q),
  .pool_wr    (pool_wr),
  .en_set_wr  (wr.en_set),
  .en_clr_wr  (wr.en_clr),
  .irq_o      (irq_o)
);

// File: tb/sim_gfx_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gfx_irq_ctrl;
  localparam int AW = 4, DW = 32, BW = 32, LW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data;
  logic ev_oom = 0, ev_fl = 0, ev_fr = 0;
  logic irq_o;
  logic [BW-1:0] pool_base_o;
  logic [LW-1:0] pool_len_o;

  always #4 clk = ~clk;

  gfx_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .POOL_BASE_W(BW), .POOL_LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .bin_oom_evt(ev_oom), .flush_done_evt(ev_fl), .frame_done_evt(ev_fr),
    .irq_o(irq_o), .pool_base_o(pool_base_o), .pool_len_o(pool_len_o));

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state, kept from the requirement text
  logic [2:0] m_pend = 0, m_en = 0;
  logic       m_cond = 0;
  logic [31:0] m_pb = 0, m_pl = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one clock of stimulus, starting and ending at a falling edge
  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic eo, input logic ef, input logic er);
    logic [2:0] setv, clrv;
    req_valid = w; req_write = w; req_addr = a; req_wdata = d;
    ev_oom = eo; ev_fl = ef; ev_fr = er;
    setv = {er, ef, eo | m_cond};
    clrv = (w && a == 0) ? d[2:0] : 3'b000;
    m_pend = (m_pend & ~clrv) | setv;
    if (w && a == 1) m_en = m_en | d[2:0];
    if (w && a == 2) m_en = m_en & ~d[2:0];
    if (w && a == 3) m_pb = d;
    if (w && a == 4) m_pl = d & 32'h00FF_FFFF;
    if (eo) m_cond = 1;
    else if (w && (a == 3 || a == 4)) m_cond = 0;
    @(negedge clk);
    req_valid = 0; req_write = 0; ev_oom = 0; ev_fl = 0; ev_fr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    req_valid = 1; req_write = 0; req_addr = a;
    #1 v = rd_data;
    req_valid = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 pending", v, 0);
    rd(1, v); chk("R1 enable", v, 0);
    rd(3, v); chk("R1 pool base", v, 0);
    rd(4, v); chk("R1 pool len", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // sweep every enable mask against every source combination
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 8; s++) begin
        step(1, 3, 32'h1000 + s, 0, 0, 0);
        step(1, 0, 32'h7, 0, 0, 0);
        step(1, 2, 32'h7, 0, 0, 0);
        step(1, 1, e, 0, 0, 0);
        rd(1, v); chk("R3 enable set", v, {29'b0, m_en});
        rd(2, v); chk("R5 enable via clear addr", v, {29'b0, m_en});
        step(0, 0, 0, s[0], s[1], s[2]);
        chk("R10 irq", {31'b0, irq_o}, {31'b0, |(m_pend & m_en)});
        rd(0, v); chk("R6 pending latch", v, {29'b0, m_pend});
        step(1, 0, 32'h7, 0, 0, 0);
        rd(0, v); chk("R7 oom held after clear", v, {29'b0, m_pend});
        chk("R10 irq after clear", {31'b0, irq_o}, {31'b0, |(m_pend & m_en)});
      end
    end

    // R4: zero bits of a clear write leave enables alone
    step(1, 1, 32'h7, 0, 0, 0);
    step(1, 2, 32'h2, 0, 0, 0);
    rd(2, v); chk("R4 enable clear", v, 32'h5);
    chk("R4 model", {29'b0, m_en}, 32'h5);

    // R2: zero bits of a status write leave pending bits alone
    step(0, 0, 0, 0, 1, 1);
    step(1, 0, 32'h2, 0, 0, 0);
    rd(0, v); chk("R2 partial clear", v, {29'b0, m_pend});
    chk("R2 bit2 kept", {31'b0, v[2]}, 1);

    // R11: event and clear of the same bit in one cycle
    step(1, 0, 32'h4, 0, 0, 1);
    rd(0, v); chk("R11 event wins", {31'b0, v[2]}, 1);
    step(1, 0, 32'h4, 0, 0, 0);
    rd(0, v); chk("R11 later clear", {31'b0, v[2]}, 0);

    // R8: supply via length register, then clear stays clear
    step(0, 0, 0, 1, 0, 0);
    step(1, 0, 32'h1, 0, 0, 0);
    rd(0, v); chk("R7 oom persists", {31'b0, v[0]}, 1);
    step(1, 4, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 0, 32'h1, 0, 0, 0);
    repeat (4) idle();
    rd(0, v); chk("R8 oom stays low", {31'b0, v[0]}, 0);
    // supply and exhaustion in the same cycle: exhaustion wins
    step(1, 3, 32'hDEAD_BEE0, 1, 0, 0);
    step(1, 0, 32'h1, 0, 0, 0);
    rd(0, v); chk("R8 event beats supply", {31'b0, v[0]}, 1);

    // R9 pool readback and outputs
    rd(3, v); chk("R9 base read", v, m_pb);
    chk("R9 base port", pool_base_o, 32'hDEAD_BEE0);
    rd(4, v); chk("R9 len read", v, 32'h00FF_FFFF);
    chk("R9 len port", {8'b0, pool_len_o}, m_pl);

    // R12 unmapped addresses
    for (int a = 5; a < 16; a++) begin
      step(1, a[3:0], 32'hFFFF_FFFF, 0, 0, 0);
      rd(a[3:0], v); chk("R12 unmapped read", v, 0);
    end
    rd(0, v); chk("R12 pending untouched", v, {29'b0, m_pend});
    rd(1, v); chk("R12 enable untouched", v, {29'b0, m_en});

    summary();
  end
endmodule